// File: doc/BRIEF.md
# Parallel Port Host Register Interface

This block is the byte-wide register file that a host processor sees when it talks to a PC-style parallel port. It holds the output data latch, a control register, a status view with a sticky bus-timeout flag, a window for interlocked (EPP) data cycles, a small transmit FIFO for the compatibility/ECP engine, and an extended control register whose upper bits pick the operating mode. Each register sits at a fixed offset from the block's base address.

The data lines can be turned around by a bit in the control register. In the reversed state the block stops driving the pins and reads return whatever the peripheral places on them. The strobing engines that talk to the peripheral are outside this block. They only see the control lines and the FIFO head, and they can pull bytes out of the FIFO with a pop strobe. They can also report a bus timeout.

Top module: `pport_host_regs`

## Requirements
- R1: Register offsets are 0x000 data, 0x001 status, 0x002 control, 0x004 EPP data, 0x400 FIFO, 0x402 extended control. A read of any other offset, or any cycle with `bus_rd` low, returns 0x00 on `bus_rdata`. Reads are combinational in the cycle `bus_rd` is high.
- R2: While control bit 5 is 0, `pins_oe` is 1, `pins_out` equals the data latch, and a data read returns the last byte written to offset 0x000 (for example 0x55, then 0xAA).
- R3: While control bit 5 is 1 (for example after writing 0xEC), `pins_oe` is 0 and a data read returns `pins_in`. Undriven pins pulled high read 0xFF. The control register reads back as written and drives `ctrl_lines`.
- R4: A status read returns `line_status` in bits 7:3, zeros in bits 2:1, and the timeout flag in bit 0. A cycle with `timeout_in` high sets the flag.
- R5: The flag clears only after two writes to the status offset: first one with bit 0 set, then one with bit 0 clear. A clearing write that is not preceded by an arming write has no effect. A set source in the same cycle wins over a clear.
- R6: Extended control bits 7:2 are written by the host. Bits 7:5 are the mode, 100 is EPP mode and 001 is bidirectional mode. Writes to bits 1:0 are ignored.
- R7: Extended control bit 0 reads 1 when the FIFO is empty, and bit 1 reads 1 when it is full.
- R8: The FIFO holds FIFO_DEPTH bytes, written at offset 0x400 and delivered in order on `fifo_head`. `fifo_avail` is high while it holds data. A high `fifo_pop` removes the head byte, and has no effect when the FIFO is empty. A write while the FIFO is full is dropped.
- R9: Outside mode 100, a read or write at offset 0x004 sets the timeout flag, and the read returns 0xFF. In mode 100, that offset behaves like the data register and the flag is left unchanged.
- R10: Reset clears the data latch, the control register and the timeout flag, and makes the extended control register read 0x01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Register offset from base |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data |
| pins_out | output | 8 | Data lines driven toward the peripheral |
| pins_oe | output | 1 | Data line output enable |
| pins_in | input | 8 | Data line values seen at the pins |
| line_status | input | 5 | Peripheral status lines |
| ctrl_lines | output | 8 | Control register contents |
| timeout_in | input | 1 | Bus-timeout report from the handshake engine |
| fifo_pop | input | 1 | Engine takes the FIFO head byte |
| fifo_head | output | 8 | Oldest FIFO byte |
| fifo_avail | output | 1 | FIFO holds at least one byte |

## Verification
The bench builds the block with the defaults, an 11-bit offset and a 16-byte FIFO. The depth is small enough to reach the full state, the dropped seventeenth write and the full-to-empty drain in directed order within a few dozen cycles. The 11-bit offset reaches the windows at 0x400 and 0x402 as well as the unused offsets between them. A random phase then mixes mode changes, turnarounds, timeout pulses, clear sequences and FIFO traffic against a queue-based model.

// File: rtl/pport_host_regs.sv
module pport_host_regs #(
  parameter int ADDR_W     = 11,
  parameter int FIFO_DEPTH = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  output logic [7:0]        pins_out,
  output logic              pins_oe,
  input  logic [7:0]        pins_in,
  input  logic [4:0]        line_status,
  output logic [7:0]        ctrl_lines,
  input  logic              timeout_in,
  input  logic              fifo_pop,
  output logic [7:0]        fifo_head,
  output logic              fifo_avail
);
  localparam int PTR_W = (FIFO_DEPTH > 1) ? $clog2(FIFO_DEPTH) : 1;
  localparam int CNT_W = $clog2(FIFO_DEPTH + 1);
  localparam logic [ADDR_W-1:0] OFS_DATA = ADDR_W'(12'h000);
  localparam logic [ADDR_W-1:0] OFS_STAT = ADDR_W'(12'h001);
  localparam logic [ADDR_W-1:0] OFS_CTRL = ADDR_W'(12'h002);
  localparam logic [ADDR_W-1:0] OFS_EPP  = ADDR_W'(12'h004);
  localparam logic [ADDR_W-1:0] OFS_FIFO = ADDR_W'(12'h400);
  localparam logic [ADDR_W-1:0] OFS_XCR  = ADDR_W'(12'h402);
  localparam logic [2:0]        MODE_EPP = 3'b100;
  localparam logic [CNT_W-1:0]  CNT_FULL = CNT_W'(FIFO_DEPTH);
  localparam logic [PTR_W-1:0]  PTR_LAST = PTR_W'(FIFO_DEPTH - 1);

  logic [7:0]       data_q, ctrl_q;
  logic [5:0]       xcr_q;
  logic             tmo_q, arm_q;
  logic [7:0]       mem [FIFO_DEPTH];
  logic [PTR_W-1:0] wp, rp;
  logic [CNT_W-1:0] cnt;
  logic [7:0]       rd_mux;

  wire       reversed  = ctrl_q[5];
  wire       is_epp    = (xcr_q[5:3] == MODE_EPP);
  wire       empty     = (cnt == '0);
  wire       full      = (cnt == CNT_FULL);
  wire       epp_hit   = (bus_wr || bus_rd) && bus_addr == OFS_EPP;
  wire       epp_bad   = epp_hit && !is_epp;
  wire       data_wr   = bus_wr && (bus_addr == OFS_DATA || (bus_addr == OFS_EPP && is_epp));
  wire       stat_wr   = bus_wr && bus_addr == OFS_STAT;
  wire       push      = bus_wr && bus_addr == OFS_FIFO && !full;
  wire       pop       = fifo_pop && !empty;
  wire       tmo_set   = timeout_in || epp_bad;
  wire       tmo_clr   = stat_wr && !bus_wdata[0] && arm_q;
  wire [7:0] data_view = reversed ? pins_in : data_q;

  assign pins_out   = data_q;
  assign pins_oe    = !reversed;
  assign ctrl_lines = ctrl_q;
  assign fifo_head  = mem[rp];
  assign fifo_avail = !empty;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data_q <= '0;
      ctrl_q <= '0;
      xcr_q  <= '0;
      tmo_q  <= 1'b0;
      arm_q  <= 1'b0;
    end else begin
      if (data_wr) data_q <= bus_wdata;
      if (bus_wr && bus_addr == OFS_CTRL) ctrl_q <= bus_wdata;
      if (bus_wr && bus_addr == OFS_XCR) xcr_q <= bus_wdata[7:2];
      if (stat_wr) arm_q <= bus_wdata[0];
      if (tmo_set) tmo_q <= 1'b1;
      else if (tmo_clr) tmo_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push) wp <= (wp == PTR_LAST) ? '0 : wp + 1'b1;
      if (pop)  rp <= (rp == PTR_LAST) ? '0 : rp + 1'b1;
      cnt <= cnt + CNT_W'(push) - CNT_W'(pop);
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= bus_wdata;
  end

  always_comb begin
    rd_mux = 8'h00;
    if (bus_addr == OFS_DATA)      rd_mux = data_view;
    else if (bus_addr == OFS_STAT) rd_mux = {line_status, 2'b00, tmo_q};
    else if (bus_addr == OFS_CTRL) rd_mux = ctrl_q;
    else if (bus_addr == OFS_EPP)  rd_mux = is_epp ? data_view : 8'hFF;
    else if (bus_addr == OFS_FIFO) rd_mux = mem[rp];
    else if (bus_addr == OFS_XCR)  rd_mux = {xcr_q, full, empty};
  end

  assign bus_rdata = bus_rd ? rd_mux : 8'h00;

  AST_TMO_INPUT: assert property (@(posedge clk) disable iff (!rst_n) timeout_in |=> tmo_q); // R4
  AST_TMO_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (tmo_q && !tmo_set && !(stat_wr && arm_q && !bus_wdata[0])) |=> tmo_q); // R5
  AST_EPP_GUARD: assert property (@(posedge clk) disable iff (!rst_n) epp_bad |=> tmo_q); // R9
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n) cnt <= CNT_FULL); // R8
  AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !fifo_pop) |=> full && $stable(wp)); // R8
  AST_EMPTY_POP: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && !(bus_wr && bus_addr == OFS_FIFO)) |=> empty && $stable(rp)); // R8
  AST_DIR_OE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == OFS_CTRL) |=> pins_oe == !$past(bus_wdata[5])); // R3
endmodule

// File: tb/sim_pport_host_regs.sv
`timescale 1ns/1ps
module sim_pport_host_regs;
  logic        clk = 0, rst_n = 0;
  logic [10:0] bus_addr = '0;
  logic        bus_wr = 0, bus_rd = 0, timeout_in = 0, fifo_pop = 0;
  logic [7:0]  bus_wdata = '0, pins_in = 8'hFF;
  logic [4:0]  line_status = '0;
  logic [7:0]  bus_rdata, pins_out, ctrl_lines, fifo_head;
  logic        pins_oe, fifo_avail;

  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  pport_host_regs u0 (.clk, .rst_n, .bus_addr, .bus_wr, .bus_rd, .bus_wdata, .bus_rdata,
    .pins_out, .pins_oe, .pins_in, .line_status, .ctrl_lines, .timeout_in,
    .fifo_pop, .fifo_head, .fifo_avail);

  // reference model
  logic [7:0] m_data, m_ctrl;
  logic [5:0] m_xcr;
  bit         m_tmo, m_arm;
  logic [7:0] q [$];

  function automatic logic [7:0] m_read(input logic [10:0] a);
    logic [7:0] dv;
    dv = m_ctrl[5] ? pins_in : m_data;
    if (!bus_rd) return 8'h00;
    case (a)
      11'h000: return dv;
      11'h001: return {line_status, 2'b00, m_tmo};
      11'h002: return m_ctrl;
      11'h004: return (m_xcr[5:3] == 3'b100) ? dv : 8'hFF;
      11'h400: return (q.size() != 0) ? q[0] : bus_rdata;
      11'h402: return {m_xcr, q.size() == 16, q.size() == 0};
      default: return 8'h00;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_data = 0; m_ctrl = 0; m_xcr = 0; m_tmo = 0; m_arm = 0; q.delete();
    end else begin
      bit epp, hit, setf, clrf;
      epp  = (m_xcr[5:3] == 3'b100);
      hit  = (bus_wr || bus_rd) && bus_addr == 11'h004;
      setf = timeout_in || (hit && !epp);
      clrf = bus_wr && bus_addr == 11'h001 && !bus_wdata[0] && m_arm;
      if (fifo_pop && q.size() != 0) void'(q.pop_front());
      if (bus_wr) begin
        case (bus_addr)
          11'h000: m_data = bus_wdata;
          11'h001: m_arm = bus_wdata[0];
          11'h002: m_ctrl = bus_wdata;
          11'h004: if (epp) m_data = bus_wdata;
          11'h400: if (q.size() + (fifo_pop && q.size() != 0 ? 1 : 0) < 16) q.push_back(bus_wdata);
          11'h402: m_xcr = bus_wdata[7:2];
          default: ;
        endcase
      end
      if (setf) m_tmo = 1;
      else if (clrf) m_tmo = 0;
    end
  end

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%02h exp=%02h t=%0t", tag, got, exp, $time);
    end
  endtask

  string rtag;
  always @(negedge clk) begin
    #2;
    if (rst_n && !done) begin
      case (bus_addr)
        11'h000: rtag = m_ctrl[5] ? "R3" : "R2";
        11'h001: rtag = "R4";
        11'h004: rtag = "R9";
        11'h400: rtag = "R8";
        11'h402: rtag = "R7";
        default: rtag = "R1";
      endcase
      check(rtag, bus_rdata, m_read(bus_addr));
      check("R3", {7'd0, pins_oe}, {7'd0, !m_ctrl[5]});
      check("R2", pins_out, m_data);
      check("R3", ctrl_lines, m_ctrl);
      check("R8", {7'd0, fifo_avail}, {7'd0, q.size() != 0});
      if (q.size() != 0) check("R8", fifo_head, q[0]);
    end
  end

  // one cycle of bus activity; inputs held from negedge to negedge
  task automatic cyc(input bit wr, input bit rd, input logic [10:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = d;
  endtask

  task automatic rd_exp(input logic [10:0] a, input logic [7:0] exp, input string tag);
    cyc(0, 1, a, 0);
    #4 check(tag, bus_rdata, exp);
  endtask

  task automatic wr(input logic [10:0] a, input logic [7:0] d);
    cyc(1, 0, a, d);
  endtask

  initial begin
    #(20 * 150000);
    checks++; fails++;
    $display("FAIL watchdog expired");
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    line_status = 5'h15;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R10: reset state
    rd_exp(11'h402, 8'h01, "R10");
    rd_exp(11'h002, 8'h00, "R10");
    rd_exp(11'h001, {5'h15, 3'b000}, "R10");
    rd_exp(11'h000, 8'h00, "R10");
    // R1: unused offset and idle read strobe
    rd_exp(11'h003, 8'h00, "R1");
    cyc(0, 0, 11'h002, 0); #4 check("R1", bus_rdata, 8'h00);
    // R2: forward latch
    wr(11'h000, 8'h55); rd_exp(11'h000, 8'h55, "R2");
    wr(11'h000, 8'hAA); rd_exp(11'h000, 8'hAA, "R2");
    // R3: reversed port
    wr(11'h002, 8'hEC); pins_in = 8'hFF; rd_exp(11'h000, 8'hFF, "R3");
    pins_in = 8'h3C; rd_exp(11'h000, 8'h3C, "R3");
    rd_exp(11'h002, 8'hEC, "R3");
    wr(11'h002, 8'h04); pins_in = 8'hFF; rd_exp(11'h000, 8'hAA, "R3");
    // R9: EPP window outside EPP mode
    rd_exp(11'h004, 8'hFF, "R9");
    rd_exp(11'h001, {5'h15, 3'b001}, "R9");
    // R5: clear needs arming first
    wr(11'h001, 8'h00); rd_exp(11'h001, {5'h15, 3'b001}, "R5");
    wr(11'h001, 8'h01); wr(11'h001, 8'h00); rd_exp(11'h001, {5'h15, 3'b000}, "R5");
    wr(11'h001, 8'h01);
    @(negedge clk); bus_wr = 1; bus_addr = 11'h001; bus_wdata = 8'h00; timeout_in = 1;
    @(negedge clk); bus_wr = 0; timeout_in = 0;
    rd_exp(11'h001, {5'h15, 3'b001}, "R5");
    // R4: timeout input
    wr(11'h001, 8'h01); wr(11'h001, 8'h00); rd_exp(11'h001, {5'h15, 3'b000}, "R4");
    @(negedge clk); bus_rd = 0; timeout_in = 1;
    @(negedge clk); timeout_in = 0;
    rd_exp(11'h001, {5'h15, 3'b001}, "R4");
    wr(11'h001, 8'h01); wr(11'h001, 8'h00);
    // R6 / R9: EPP mode aliasing
    wr(11'h402, 8'h80); wr(11'h004, 8'h5A);
    rd_exp(11'h004, 8'h5A, "R9"); rd_exp(11'h000, 8'h5A, "R9");
    rd_exp(11'h001, {5'h15, 3'b000}, "R9");
    wr(11'h402, 8'hFF); rd_exp(11'h402, 8'hFD, "R6");
    wr(11'h402, 8'h20); rd_exp(11'h402, 8'h21, "R6");
    // R7 / R8: fill, overflow, drain
    for (int i = 0; i < 17; i++) wr(11'h400, 8'(8'h10 + i));
    rd_exp(11'h402, 8'h22, "R7");
    for (int i = 0; i < 16; i++) begin
      rd_exp(11'h400, 8'(8'h10 + i), "R8");
      fifo_pop = 1; @(negedge clk); fifo_pop = 0;
    end
    rd_exp(11'h402, 8'h21, "R7");
    fifo_pop = 1; @(negedge clk); fifo_pop = 0;
    rd_exp(11'h402, 8'h21, "R8");
    // random mix against the model
    for (int i = 0; i < 4000; i++) begin
      logic [10:0] a;
      case ($urandom_range(0, 7))
        0: a = 11'h000; 1: a = 11'h001; 2: a = 11'h002; 3: a = 11'h004;
        4, 5: a = 11'h400; 6: a = 11'h402; default: a = 11'($urandom_range(0, 2047));
      endcase
      @(negedge clk);
      bus_addr = a;
      bus_wr = ($urandom_range(0, 2) == 0);
      bus_rd = !bus_wr && ($urandom_range(0, 1) == 0);
      bus_wdata = (a == 11'h402 && $urandom_range(0, 1) == 0) ? 8'h80 : 8'($urandom);
      timeout_in = ($urandom_range(0, 15) == 0);
      fifo_pop = ($urandom_range(0, 3) == 0);
      pins_in = ($urandom_range(0, 1) == 0) ? 8'hFF : 8'($urandom);
      line_status = 5'($urandom);
    end
    @(negedge clk);
    bus_wr = 0; bus_rd = 0; timeout_in = 0; fifo_pop = 0;
    @(negedge clk);
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule